// File: doc/BRIEF.md
# Prioritised 32-Source Interrupt Controller

This block collects up to 32 interrupt request lines and turns them into two processor-facing lines: a normal interrupt and a critical interrupt. Every source is conditioned on its own. A polarity bit says whether the line is asserted high or low. A trigger bit chooses between level sensitivity and edge sensitivity. A route bit sends the source to the normal line or to the critical line. Conditioned requests are latched in a status register. Software acknowledges a source, which also ends the interrupt, by writing a one to that source's status bit.

An enable register masks the latched status before it reaches the output lines. The masked status can be read back. The controller also reports the number of the highest-priority pending source, with a valid flag. Priority is fixed: the lower the source number, the higher the priority. Software reaches the registers through a single-cycle word-addressed write port and a combinational read port.

Top module: `src_irq_ctrl`

## Requirements
- R1: Writing the status register (word address 0) clears each status bit whose written bit is 1 and leaves each bit whose written bit is 0 unchanged. In the cycle of such a write, the clear takes priority over a new set of the same bit.
- R2: Word address 1 is the enable register and resets to all zeros. A disabled source still latches into status, but it drives no output line and is not reported as pending.
- R3: Word address 2 is the polarity register and resets to all ones. A 1 makes the source active when its line is high; a 0 makes it active when its line is low.
- R4: Word address 3 is the trigger register and resets to all zeros. A 0 makes the source level-sensitive: at every clock edge where the source is active, its status bit is set, so a source that is still asserted is set again one cycle after being cleared.
- R5: A 1 in the trigger register makes the source edge-sensitive. Its status bit is set only at a clock edge where the source is active and was inactive at the previous edge. A source held active does not set the bit again after it is cleared.
- R6: Word address 4 is the route register and resets to all ones. The normal output is high when any enabled pending source has route 1. The critical output is high when any enabled pending source has route 0.
- R7: Word address 5 is read-only and returns status AND enable. Writes to it have no effect.
- R8: The pending number output gives the lowest-numbered source that is both enabled and pending. The valid output is high exactly when such a source exists.
- R9: Source n is input line irq_i[n] and occupies bus bit 31-n in every per-source register.
- R10: Word address 6 is read-only. Bit 31 holds the valid flag and bits 4:0 hold the pending number. Word address 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 32 | Raw request lines, bit n is source n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| int_o | output | 1 | Normal interrupt line |
| crit_o | output | 1 | Critical interrupt line |
| id_o | output | 5 | Highest-priority pending source number |
| id_valid_o | output | 1 | id_o is meaningful |

## Verification
Properties check the following on every cycle:
- acknowledge writes clear the bits they name, and every other latched bit stays set;
- an active level source is latched at the next edge;
- the reported number is a pending enabled source, and no lower-numbered one is pending;
- the output lines and the valid flag agree;
- the enable register comes out of reset cleared.

Only the bench scenarios can show:
- edge sources ignoring a held line after acknowledge;
- the polarity and route encodings;
- the reversed bus bit order;
- the fact that writes to the read-only words change nothing.

// File: rtl/src_irq_pkg.sv
package src_irq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_STATUS = 3'd0,
    RA_ENABLE = 3'd1,
    RA_POL    = 3'd2,
    RA_TRIG   = 3'd3,
    RA_ROUTE  = 3'd4,
    RA_MASKED = 3'd5,
    RA_ID     = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/src_irq_cond.sv
module src_irq_cond #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] trig_i,
  output logic [NUM_SRC-1:0] set_o
);
  logic [NUM_SRC-1:0] act;
  logic [NUM_SRC-1:0] act_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    // active when the line level equals the polarity bit
    assign act[g]   = irq_i[g] ~^ pol_i[g];
    assign set_o[g] = trig_i[g] ? (act[g] & ~act_q[g]) : act[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act;
  end
endmodule

// File: rtl/src_irq_regs.sv
module src_irq_regs
  import src_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] set_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic [NUM_SRC-1:0] pol_o,
  output logic [NUM_SRC-1:0] trig_o,
  output logic [NUM_SRC-1:0] route_o
);
  logic [NUM_SRC-1:0] wsrc;
  logic [NUM_SRC-1:0] clr;
  logic wr_st, wr_en, wr_pol, wr_trig, wr_route;

  // bus bit 31-n carries source n
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flip
    assign wsrc[g] = wdata_i[NUM_SRC-1-g];
  end

  assign wr_st    = wr_en_i && (addr_i == RA_STATUS);
  assign wr_en    = wr_en_i && (addr_i == RA_ENABLE);
  assign wr_pol   = wr_en_i && (addr_i == RA_POL);
  assign wr_trig  = wr_en_i && (addr_i == RA_TRIG);
  assign wr_route = wr_en_i && (addr_i == RA_ROUTE);
  assign clr      = wr_st ? wsrc : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      enable_o <= '0;
      pol_o    <= '1;
      trig_o   <= '0;
      route_o  <= '1;
    end else begin
      // acknowledge wins over a set in the same cycle
      status_o <= (status_o | set_i) & ~clr;
      if (wr_en)    enable_o <= wsrc;
      if (wr_pol)   pol_o    <= wsrc;
      if (wr_trig)  trig_o   <= wsrc;
      if (wr_route) route_o  <= wsrc;
    end
  end
endmodule

// File: rtl/src_irq_prio.sv
module src_irq_prio #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDW = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] masked_i,
  output logic [IDW-1:0]     id_o,
  output logic               valid_o
);
  always_comb begin
    id_o    = '0;
    valid_o = 1'b0;
    // descending scan so the lowest set index is kept
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (masked_i[i]) begin
        id_o    = IDW'(i);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/src_irq_ctrl.sv
module src_irq_ctrl
  import src_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDW = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               wr_en_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               int_o,
  output logic               crit_o,
  output logic [IDW-1:0]     id_o,
  output logic               id_valid_o
);
  logic [NUM_SRC-1:0] status_s, enable_s, pol_s, trig_s, route_s, set_s, masked_s;
  logic [NUM_SRC-1:0] status_b, enable_b, pol_b, trig_b, route_b, masked_b, id_b;

  src_irq_cond #(.NUM_SRC(NUM_SRC)) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .pol_i  (pol_s),
    .trig_i (trig_s),
    .set_o  (set_s)
  );

  src_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .set_i    (set_s),
    .status_o (status_s),
    .enable_o (enable_s),
    .pol_o    (pol_s),
    .trig_o   (trig_s),
    .route_o  (route_s)
  );

  assign masked_s = status_s & enable_s;
  assign int_o    = |(masked_s & route_s);
  assign crit_o   = |(masked_s & ~route_s);

  src_irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .masked_i (masked_s),
    .id_o     (id_o),
    .valid_o  (id_valid_o)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bus
    assign status_b[NUM_SRC-1-g] = status_s[g];
    assign enable_b[NUM_SRC-1-g] = enable_s[g];
    assign pol_b[NUM_SRC-1-g]    = pol_s[g];
    assign trig_b[NUM_SRC-1-g]   = trig_s[g];
    assign route_b[NUM_SRC-1-g]  = route_s[g];
    assign masked_b[NUM_SRC-1-g] = masked_s[g];
  end

  always_comb begin
    id_b            = '0;
    id_b[NUM_SRC-1] = id_valid_o;
    id_b[IDW-1:0]   = id_o;
  end

  always_comb begin
    case (addr_i)
      RA_STATUS: rdata_o = status_b;
      RA_ENABLE: rdata_o = enable_b;
      RA_POL:    rdata_o = pol_b;
      RA_TRIG:   rdata_o = trig_b;
      RA_ROUTE:  rdata_o = route_b;
      RA_MASKED: rdata_o = masked_b;
      RA_ID:     rdata_o = id_b;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/src_irq_ctrl_chk.sv
module src_irq_ctrl_chk
  import src_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDW = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_i,
  input logic               wr_en_i,
  input logic [REG_AW-1:0]  addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic               int_o,
  input logic               crit_o,
  input logic [IDW-1:0]     id_o,
  input logic               id_valid_o,
  input logic [NUM_SRC-1:0] status_i,
  input logic [NUM_SRC-1:0] enable_i,
  input logic [NUM_SRC-1:0] pol_i,
  input logic [NUM_SRC-1:0] trig_i
);
  logic [NUM_SRC-1:0] wsrc, clr, act, masked;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flip
    assign wsrc[g] = wdata_i[NUM_SRC-1-g];
  end
  assign clr    = (wr_en_i && addr_i == RA_STATUS) ? wsrc : '0;
  assign act    = ~(irq_i ^ pol_i);
  assign masked = status_i & enable_i;

  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr) |=> ((status_i & $past(clr)) == '0));

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & $past(status_i & ~clr)) == $past(status_i & ~clr)));

  always @(posedge clk_i) begin
    if (!rst_ni) p_en_reset_r2: assert (enable_i == '0);
  end

  p_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(~trig_i & act & ~clr) & ~status_i) == '0));

  p_out_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o || crit_o) == id_valid_o);

  p_id_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |-> masked[id_o]);

  p_id_lowest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |-> ((masked & ((NUM_SRC'(1) << id_o) - NUM_SRC'(1))) == '0));

  p_none_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked == '0) |-> !id_valid_o);
endmodule

bind src_irq_ctrl src_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .int_o      (int_o),
  .crit_o     (crit_o),
  .id_o       (id_o),
  .id_valid_o (id_valid_o),
  .status_i   (status_s),
  .enable_i   (enable_s),
  .pol_i      (pol_s),
  .trig_i     (trig_s)
);

// File: tb/src_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module src_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        int_w, crit_w, vld_w;
  logic [4:0]  id_w;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  src_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .int_o(int_w), .crit_o(crit_w),
    .id_o(id_w), .id_valid_o(vld_w)
  );

  // reference model, source order
  logic [31:0] m_st, m_en, m_pol, m_trig, m_route, m_prev;

  function automatic logic [31:0] flip(input logic [31:0] v);
    for (int n = 0; n < 32; n++) flip[31-n] = v[n];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] nst, nprev, wsrc;
    if (!rst_n) begin
      m_st = '0; m_en = '0; m_pol = '1; m_trig = '0; m_route = '1; m_prev = '0;
    end else begin
      wsrc = flip(wdata);
      for (int n = 0; n < 32; n++) begin
        bit act, hit, clr;
        act = (irq[n] == m_pol[n]);
        hit = m_trig[n] ? (act && !m_prev[n]) : act;
        clr = wr_en && (addr == 3'd0) && wsrc[n];
        nst[n] = clr ? 1'b0 : (m_st[n] | hit);
        nprev[n] = act;
      end
      m_st = nst;
      m_prev = nprev;
      if (wr_en) begin
        case (addr)
          3'd1: m_en = wsrc;
          3'd2: m_pol = wsrc;
          3'd3: m_trig = wsrc;
          3'd4: m_route = wsrc;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_id();
    logic [31:0] mk;
    mk = m_st & m_en;
    exp_id = -1;
    for (int n = 31; n >= 0; n--) if (mk[n]) exp_id = n;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    int id;
    id = exp_id();
    case (a)
      3'd0: exp_rd = flip(m_st);
      3'd1: exp_rd = flip(m_en);
      3'd2: exp_rd = flip(m_pol);
      3'd3: exp_rd = flip(m_trig);
      3'd4: exp_rd = flip(m_route);
      3'd5: exp_rd = flip(m_st & m_en);
      3'd6: exp_rd = (id < 0) ? 32'h0 : (32'h8000_0000 | 32'(id));
      default: exp_rd = 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [31:0] mk;
      int id;
      mk = m_st & m_en;
      id = exp_id();
      check("R6 int_o model", 32'(int_w), 32'(|(mk & m_route)));
      check("R6 crit_o model", 32'(crit_w), 32'(|(mk & ~m_route)));
      check("R8 id_valid_o model", 32'(vld_w), 32'(id >= 0));
      if (id >= 0) check("R8 id_o model", 32'(id_w), 32'(id));
      check("R10 rdata_o model", rdata, exp_rd(addr));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // reset state
    rd_chk(3'd1, 32'h0, "R2 enable reset");
    rd_chk(3'd2, 32'hFFFF_FFFF, "R3 polarity reset");
    rd_chk(3'd3, 32'h0, "R4 trigger reset");
    rd_chk(3'd4, 32'hFFFF_FFFF, "R6 route reset");
    check("R8 valid low after reset", 32'(vld_w), 32'd0);
    check("R6 outputs low after reset", 32'({int_w, crit_w}), 32'd0);

    // level source 3 (bit 28), sources 5 (bit 26) and 10 (bit 21) enabled
    wr(3'd1, 32'h1420_0000);
    irq[3] = 1'b1;
    step();
    #1;
    check("R4 level source raises int_o", 32'(int_w), 32'd1);
    check("R8 id is 3", 32'(id_w), 32'd3);
    rd_chk(3'd5, 32'h1000_0000, "R9 source 3 at bit 28 masked");
    wr(3'd0, 32'h1000_0000);
    rd_chk(3'd0, 32'h0, "R1 clear wins over level set");
    step();
    rd_chk(3'd0, 32'h1000_0000, "R4 level re-sets after clear");
    wr(3'd0, 32'h0);
    rd_chk(3'd0, 32'h1000_0000, "R1 zero write keeps bit");
    irq[3] = 1'b0;
    wr(3'd0, 32'hFFFF_FFFF);
    step();
    rd_chk(3'd0, 32'h0, "R1 all-ones write clears");

    // edge source 5
    wr(3'd3, 32'h0400_0000);
    irq[5] = 1'b1;
    step();
    rd_chk(3'd0, 32'h0400_0000, "R5 edge sets status");
    wr(3'd0, 32'h0400_0000);
    step(); step();
    rd_chk(3'd0, 32'h0, "R5 held edge source stays clear");
    irq[5] = 1'b0;
    step();
    irq[5] = 1'b1;
    step();
    rd_chk(3'd0, 32'h0400_0000, "R5 new edge sets again");
    irq[5] = 1'b0;
    wr(3'd0, 32'h0400_0000);

    // active-low source 10
    wr(3'd2, 32'hFFDF_FFFF);
    step();
    rd_chk(3'd0, 32'h0020_0000, "R3 active-low source pending");
    check("R8 id is 10", 32'(id_w), 32'd10);
    check("R6 route 1 drives int_o", 32'({int_w, crit_w}), 32'b10);
    wr(3'd4, 32'hFFDF_FFFF);
    #1;
    check("R6 route 0 drives crit_o", 32'({int_w, crit_w}), 32'b01);
    irq[3] = 1'b1;
    step();
    #1;
    check("R8 source 3 beats source 10", 32'(id_w), 32'd3);
    check("R6 both lines", 32'({int_w, crit_w}), 32'b11);
    irq[3] = 1'b0;

    // disable source 3 while latched
    wr(3'd1, 32'h0420_0000);
    rd_chk(3'd0, 32'h1020_0000, "R2 disabled source still latched");
    rd_chk(3'd5, 32'h0020_0000, "R7 masked view");
    check("R2 disabled source not reported", 32'(id_w), 32'd10);
    check("R2 disabled source off int_o", 32'(int_w), 32'd0);
    wr(3'd5, 32'h0);
    rd_chk(3'd5, 32'h0020_0000, "R7 write to masked ignored");
    rd_chk(3'd0, 32'h1020_0000, "R7 write to masked leaves status");

    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'hFFFF_FFFF);
    step();
    #1;
    check("R8 valid low when none pending", 32'(vld_w), 32'd0);
    rd_chk(3'd7, 32'h0, "R10 unused word reads zero");

    // extremes of the bit mapping
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0);
    irq[31] = 1'b1;
    step();
    rd_chk(3'd5, 32'h0000_0001, "R9 source 31 at bit 0");
    irq[0] = 1'b1;
    step();
    rd_chk(3'd5, 32'h8000_0001, "R9 source 0 at bit 31");
    rd_chk(3'd6, 32'h8000_0000, "R10 id word valid bit and id 0");
    irq = '0;
    wr(3'd0, 32'hFFFF_FFFF);
    step();
    rd_chk(3'd6, 32'h0, "R10 id word empty");
    step();
    finish_run();
  end
endmodule